// File: doc/BRIEF.md
# Burst write engine for a synchronous DRAM device

This block sits on the device side of a single data rate synchronous DRAM. It samples the command pins on every rising clock edge and decodes them. It records which banks hold an open row and how long each row has been open. When a valid Write arrives, it stores a burst of data words into an attached storage array, one word per clock edge. The first word is taken on the same edge as the command. The column sequence follows the burst length and ordering held in a mode register. A full-page burst wraps past the last column and keeps going until another command stops it.

A later Write, a Read or a Precharge can cut a burst short on any cycle. A new Write starts a fresh burst at its own column. A Write to a bank that is closed, or to a bank whose row has not been open for long enough, writes nothing and raises an error pulse. A per-word mask suppresses single words while the column sequence keeps advancing.

The controller is a two-state machine. `ST_IDLE` moves to `ST_BURST` when a Write is accepted with a burst length above one. `ST_BURST` stays in `ST_BURST` when a new accepted Write restarts the burst, or when the burst continues with no stopping command. `ST_BURST` returns to `ST_IDLE` on a Read, a Precharge, a rejected Write, an accepted single-word Write, or after the last word of a fixed-length burst.

Top module: `sdram_wburst_engine`

## Requirements
- R1: With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as 011 Activate, 100 Write, 101 Read, 010 Precharge and 000 Mode set. Any other pattern, or `cs_n` high, is a no-operation.
- R2: Mode set loads `addr[2:0]` as the length code (0→1, 1→2, 2→4, 3→8, 7→full page) and `addr[3]` as the ordering (0 sequential, 1 interleaved). Codes 4 to 6 leave the mode unchanged. After reset the mode is length 4, sequential.
- R3: A Write is accepted only if its bank was activated at least `TRCD` edges earlier and is still open. Otherwise `proto_err` is high for one cycle, nothing is written, and any running burst ends.
- R4: The word on `dq_in` at the Write edge is presented on `arr_we`/`arr_col`/`arr_data`/`arr_bank` in the following cycle, with `arr_col` equal to `addr[7:0]`. Each later word follows one cycle after its own edge.
- R5: For sequential bursts of length BL, word i goes to column `(start & ~(BL-1)) | ((start + i) & (BL-1))`.
- R6: For interleaved bursts, word i goes to column `(start & ~(BL-1)) | ((start ^ i) & (BL-1))`.
- R7: A full-page burst writes to column `(start + i) mod 256` and never ends by itself. The ordering bit is ignored.
- R8: A Read or a Precharge during a burst ends it. The word on that edge is not written.
- R9: A Write during a burst starts a new burst at its own column on its own edge. The rest of the old burst is dropped.
- R10: Once a burst has ended, `arr_we` stays low until the next accepted Write.
- R11: `dm` high on an edge of a burst keeps `arr_we` low for that word, and the column sequence still advances.
- R12: Precharge closes bank `ba`, or all banks if `addr[10]` is high. A later Write to a closed bank is rejected as in R3.
- R13: A Write with `addr[10]` high closes its bank when its burst completes its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank select |
| addr | input | ADDR_W (11) | Address: column in [7:0], mode fields in [3:0], auto-precharge/all-banks in [10] |
| dq_in | input | DATA_W (16) | Write data word |
| dm | input | 1 | Per-word write mask |
| arr_we | output | 1 | Write strobe to the storage array |
| arr_bank | output | BA_W (2) | Bank of the word being written |
| arr_col | output | COL_W (8) | Column of the word being written |
| arr_data | output | DATA_W (16) | Data of the word being written |
| proto_err | output | 1 | One-cycle pulse for a rejected Write |

## Verification
A wrong burst index or a wrong latched mode shows on `arr_col` in the very next cycle after the edge that used it. A wrong state-machine exit shows either as a strobe that goes on past the burst length or as a missing strobe one cycle after an interrupting edge. A wrong open-row counter shows at the first Write to that bank, as a `proto_err` pulse where a strobe was due, or the reverse. The vectors therefore check every output cycle of each burst and place Writes exactly on the `TRCD` boundary and one edge before it.

// File: rtl/wb_pkg.sv
package wb_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_WR,
        CMD_RD,
        CMD_PRE,
        CMD_MRS
    } cmd_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_BURST
    } state_e;

    // Burst mode: full page flag, log2 of fixed length, interleave flag
    typedef struct packed {
        logic       full;
        logic [1:0] lg;
        logic       ilv;
    } mode_t;

    localparam mode_t MODE_RESET = '{full: 1'b0, lg: 2'd2, ilv: 1'b0};

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b100:  c = CMD_WR;
                3'b101:  c = CMD_RD;
                3'b010:  c = CMD_PRE;
                3'b000:  c = CMD_MRS;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic multi_word(input mode_t m);
        return m.full || (m.lg != 2'd0);
    endfunction

endpackage

// File: rtl/wb_mode_reg.sv
module wb_mode_reg
    import wb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_en,
    input  logic [3:0] code,
    output mode_t      mode_o
);

    mode_t mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else if (load_en) begin
            unique case (code[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: begin
                    mode_q.full <= 1'b0;
                    mode_q.lg   <= code[1:0];
                    mode_q.ilv  <= code[3];
                end
                3'd7: begin
                    mode_q.full <= 1'b1;
                    mode_q.lg   <= 2'd0;
                    mode_q.ilv  <= code[3];
                end
                default: mode_q <= mode_q;
            endcase
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/wb_bank_track.sv
module wb_bank_track #(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CW       = $clog2(TRCD + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_en,
    input  logic [BA_W-1:0]      act_bank,
    input  logic                 pre_en,
    input  logic                 pre_all,
    input  logic [BA_W-1:0]      pre_bank,
    input  logic                 close_en,
    input  logic [BA_W-1:0]      close_bank,
    output logic [NUM_BANKS-1:0] ready_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic          open_q;
        logic [CW-1:0] age_q;
        logic          act_hit, pre_hit, close_hit;

        assign act_hit   = act_en && (act_bank == BA_W'(b));
        assign pre_hit   = pre_en && (pre_all || (pre_bank == BA_W'(b)));
        assign close_hit = close_en && (close_bank == BA_W'(b));

        // age_q counts edges since the Activate, saturating at TRCD
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                age_q  <= '0;
            end else if (act_hit) begin
                open_q <= 1'b1;
                age_q  <= CW'(1);
            end else if (pre_hit || close_hit) begin
                open_q <= 1'b0;
                age_q  <= '0;
            end else if (open_q && (age_q != CW'(TRCD))) begin
                age_q  <= age_q + CW'(1);
            end
        end

        assign ready_o[b] = open_q && (age_q == CW'(TRCD));

        if (TRCD > 1) begin : g_wait_chk
            assert_act_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
                act_hit |=> !ready_o[b]);
        end

        assert_pre_closes_R12: assert property (@(posedge clk) disable iff (!rst_n)
            pre_hit |=> !ready_o[b]);
    end

endmodule

// File: rtl/wb_col_gen.sv
module wb_col_gen
    import wb_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [COL_W-1:0] idx_i,
    input  mode_t            mode_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] mask;

    always_comb begin
        mask = (COL_W'(1) << mode_i.lg) - COL_W'(1);
        if (mode_i.full) begin
            col_o = start_i + idx_i;
        end else if (mode_i.ilv) begin
            col_o = (start_i & ~mask) | ((start_i ^ idx_i) & mask);
        end else begin
            col_o = (start_i & ~mask) | ((start_i + idx_i) & mask);
        end
    end

endmodule

// File: rtl/sdram_wburst_engine.sv
module sdram_wburst_engine
    import wb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 11,
    parameter int COL_W     = 8,
    parameter int DATA_W    = 16,
    parameter int TRCD      = 3,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              dm,
    output logic              arr_we,
    output logic [BA_W-1:0]   arr_bank,
    output logic [COL_W-1:0]  arr_col,
    output logic [DATA_W-1:0] arr_data,
    output logic              proto_err
);

    cmd_e                 cmd;
    state_e               state_q, state_d;
    mode_t                mode_cur, mode_q, gen_mode;
    logic [NUM_BANKS-1:0] bank_ready;

    logic                 wr_cmd, wr_ok, stop_cmd, last_word, emit;
    logic                 close_en;
    logic [BA_W-1:0]      close_bank;

    logic [BA_W-1:0]      bank_q;
    logic [COL_W-1:0]     start_q, idx_q;
    logic                 ap_q;
    logic [COL_W-1:0]     gen_start, gen_idx, gen_col;

    logic                 we_q, err_q, word_q, cont_q;
    logic [BA_W-1:0]      bank_o_q;
    logic [COL_W-1:0]     col_q;
    logic [DATA_W-1:0]    data_q;
    logic                 unused_addr;

    assign unused_addr = ^addr;

    // ---------------- command decode ----------------
    assign cmd      = decode_cmd(cs_n, ras_n, cas_n, we_n);
    assign wr_cmd   = (cmd == CMD_WR);
    assign wr_ok    = wr_cmd && bank_ready[ba];
    assign stop_cmd = (cmd == CMD_WR) || (cmd == CMD_RD) || (cmd == CMD_PRE);

    wb_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (cmd == CMD_MRS),
        .code    (addr[3:0]),
        .mode_o  (mode_cur)
    );

    wb_bank_track #(
        .NUM_BANKS (NUM_BANKS),
        .TRCD      (TRCD)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_en     (cmd == CMD_ACT),
        .act_bank   (ba),
        .pre_en     (cmd == CMD_PRE),
        .pre_all    (addr[AP_BIT]),
        .pre_bank   (ba),
        .close_en   (close_en),
        .close_bank (close_bank),
        .ready_o    (bank_ready)
    );

    // ---------------- column sequencing ----------------
    assign gen_start = wr_ok ? addr[COL_W-1:0] : start_q;
    assign gen_idx   = wr_ok ? '0 : idx_q;
    assign gen_mode  = wr_ok ? mode_cur : mode_q;

    wb_col_gen #(.COL_W(COL_W)) u_col (
        .start_i (gen_start),
        .idx_i   (gen_idx),
        .mode_i  (gen_mode),
        .col_o   (gen_col)
    );

    assign last_word = !mode_q.full &&
                       (idx_q == ((COL_W'(1) << mode_q.lg) - COL_W'(1)));
    assign emit      = wr_ok || ((state_q == ST_BURST) && !stop_cmd);

    // auto-precharge closes the bank only on natural completion
    assign close_en   = ((state_q == ST_BURST) && !stop_cmd && last_word && ap_q) ||
                        (wr_ok && !multi_word(mode_cur) && addr[AP_BIT]);
    assign close_bank = wr_ok ? ba : bank_q;

    // ---------------- state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ok && multi_word(mode_cur)) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (wr_ok)                      state_d = multi_word(mode_cur) ? ST_BURST : ST_IDLE;
                else if (stop_cmd || last_word) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- burst context and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q   <= '0;
            start_q  <= '0;
            idx_q    <= '0;
            mode_q   <= MODE_RESET;
            ap_q     <= 1'b0;
            we_q     <= 1'b0;
            err_q    <= 1'b0;
            word_q   <= 1'b0;
            cont_q   <= 1'b0;
            bank_o_q <= '0;
            col_q    <= '0;
            data_q   <= '0;
        end else begin
            err_q  <= wr_cmd && !wr_ok;
            word_q <= emit;
            cont_q <= emit && !wr_ok;
            we_q   <= emit && !dm;
            if (emit) begin
                col_q    <= gen_col;
                data_q   <= dq_in;
                bank_o_q <= wr_ok ? ba : bank_q;
            end
            if (wr_ok) begin
                bank_q  <= ba;
                start_q <= addr[COL_W-1:0];
                idx_q   <= COL_W'(1);
                mode_q  <= mode_cur;
                ap_q    <= addr[AP_BIT];
            end else if ((state_q == ST_BURST) && !stop_cmd) begin
                idx_q   <= idx_q + COL_W'(1);
            end
        end
    end

    assign arr_we    = we_q;
    assign arr_bank  = bank_o_q;
    assign arr_col   = col_q;
    assign arr_data  = data_q;
    assign proto_err = err_q;

    // ---------------- assertions ----------------
    assert_err_blocks_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !arr_we);

    assert_first_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (word_q && (arr_col == $past(addr[COL_W-1:0]))));

    assert_fullpage_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_q && mode_q.full) |-> (arr_col == $past(arr_col) + COL_W'(1)));

    assert_interrupt_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BURST) && ((cmd == CMD_RD) || (cmd == CMD_PRE))) |=> !word_q);

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !wr_cmd) |=> !arr_we);

endmodule

// File: tb/test_sdram_wburst_engine.sv
`timescale 1ns/1ps
module test_sdram_wburst_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [10:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic        dm = 1'b0;
    logic        arr_we, proto_err;
    logic [1:0]  arr_bank;
    logic [7:0]  arr_col;
    logic [15:0] arr_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_wburst_engine i_sdram_wburst_engine (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .dq_in(dq_in), .dm(dm),
        .arr_we(arr_we), .arr_bank(arr_bank), .arr_col(arr_col),
        .arr_data(arr_data), .proto_err(proto_err)
    );

    // command codes: 0 nop, 1 activate, 2 write, 3 read, 4 precharge, 5 mode set
    typedef struct packed {
        logic [2:0]  c;
        logic [1:0]  b;
        logic [10:0] a;
        logic [15:0] d;
        logic        m;
        logic        xwe;
        logic [7:0]  xcol;
        logic        xerr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{3'd5, 2'd0, 11'h002, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 length 4 seq
        '{3'd1, 2'd0, 11'h010, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd1},  // R1 activate
        '{3'd0, 2'd0, 11'h000, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd1},
        '{3'd2, 2'd0, 11'h000, 16'h1111, 1'b0, 1'b0, 8'h00, 1'b1, 4'd3},  // R3 one edge early
        '{3'd2, 2'd0, 11'h005, 16'h00A0, 1'b0, 1'b1, 8'h05, 1'b0, 4'd4},  // R4 first word same edge
        '{3'd0, 2'd0, 11'h000, 16'h00A1, 1'b0, 1'b1, 8'h06, 1'b0, 4'd5},  // R5
        '{3'd0, 2'd0, 11'h000, 16'h00A2, 1'b1, 1'b0, 8'h00, 1'b0, 4'd11}, // R11 masked
        '{3'd0, 2'd0, 11'h000, 16'h00A3, 1'b0, 1'b1, 8'h04, 1'b0, 4'd5},  // R5 wrap in block
        '{3'd0, 2'd0, 11'h000, 16'h00A4, 1'b0, 1'b0, 8'h00, 1'b0, 4'd10}, // R10 extra data
        '{3'd5, 2'd0, 11'h00A, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 length 4 ilv
        '{3'd2, 2'd0, 11'h006, 16'h00B0, 1'b0, 1'b1, 8'h06, 1'b0, 4'd6},  // R6
        '{3'd0, 2'd0, 11'h000, 16'h00B1, 1'b0, 1'b1, 8'h07, 1'b0, 4'd6},
        '{3'd0, 2'd0, 11'h000, 16'h00B2, 1'b0, 1'b1, 8'h04, 1'b0, 4'd6},
        '{3'd2, 2'd0, 11'h010, 16'h00C0, 1'b0, 1'b1, 8'h10, 1'b0, 4'd9},  // R9 restart
        '{3'd0, 2'd0, 11'h000, 16'h00C1, 1'b0, 1'b1, 8'h11, 1'b0, 4'd9},
        '{3'd3, 2'd0, 11'h000, 16'h00C2, 1'b0, 1'b0, 8'h00, 1'b0, 4'd8},  // R8 read stops
        '{3'd0, 2'd0, 11'h000, 16'h00C3, 1'b0, 1'b0, 8'h00, 1'b0, 4'd10},
        '{3'd5, 2'd0, 11'h003, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 length 8 seq
        '{3'd2, 2'd0, 11'h00E, 16'h00D0, 1'b0, 1'b1, 8'h0E, 1'b0, 4'd5},
        '{3'd0, 2'd0, 11'h000, 16'h00D1, 1'b0, 1'b1, 8'h0F, 1'b0, 4'd5},
        '{3'd0, 2'd0, 11'h000, 16'h00D2, 1'b0, 1'b1, 8'h08, 1'b0, 4'd5},
        '{3'd4, 2'd0, 11'h000, 16'h00D3, 1'b0, 1'b0, 8'h00, 1'b0, 4'd8},  // R8 precharge stops
        '{3'd2, 2'd0, 11'h000, 16'h00D4, 1'b0, 1'b0, 8'h00, 1'b1, 4'd12}, // R12 closed bank
        '{3'd0, 2'd0, 11'h000, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd10}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive one command at a negedge, then wait until after the next rising edge
    task automatic put(input int c, input logic [1:0] b, input logic [10:0] a,
                       input logic [15:0] d, input logic m, input logic desel);
        cs_n = desel || (c == 0);
        case (c)
            1:       {ras_n, cas_n, we_n} = 3'b011;
            2:       {ras_n, cas_n, we_n} = 3'b100;
            3:       {ras_n, cas_n, we_n} = 3'b101;
            4:       {ras_n, cas_n, we_n} = 3'b010;
            5:       {ras_n, cas_n, we_n} = 3'b000;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        ba = b; addr = a; dq_in = d; dm = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R4 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(arr_we == 1'b0 && proto_err == 1'b0, "reset R4 outputs idle",
            {30'd0, arr_we, proto_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(arr_we == 1'b0 && arr_col == 8'h00, "reset R10 quiet after release",
            {23'd0, arr_we, arr_col}, 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            put(TBL[i].c, TBL[i].b, TBL[i].a, TBL[i].d, TBL[i].m, 1'b0);
            chk(arr_we == TBL[i].xwe, $sformatf("R%0d row %0d strobe", TBL[i].rq, i),
                {31'd0, arr_we}, {31'd0, TBL[i].xwe});
            chk(proto_err == TBL[i].xerr, $sformatf("R%0d row %0d error", TBL[i].rq, i),
                {31'd0, proto_err}, {31'd0, TBL[i].xerr});
            if (TBL[i].xwe) begin
                chk(arr_col == TBL[i].xcol && arr_data == TBL[i].d,
                    $sformatf("R%0d row %0d column/data", TBL[i].rq, i),
                    {8'd0, arr_col, arr_data}, {8'd0, TBL[i].xcol, TBL[i].d});
            end
        end

        // R7: full page, ordering bit set but ignored, wraps past column 255
        put(5, 2'd0, 11'h00F, 16'h0, 1'b0, 1'b0);
        put(1, 2'd2, 11'h000, 16'h0, 1'b0, 1'b0);
        put(0, 2'd0, 11'h000, 16'h0, 1'b0, 1'b0);
        put(0, 2'd0, 11'h000, 16'h0, 1'b0, 1'b0);
        put(2, 2'd2, 11'h0FE, 16'h5000, 1'b0, 1'b0);
        chk(arr_we && arr_col == 8'hFE && arr_bank == 2'd2, "R7 full page start",
            {22'd0, arr_we, arr_bank, arr_col}, {22'd0, 1'b1, 2'd2, 8'hFE});
        for (int k = 1; k < 300; k++) begin
            put(0, 2'd0, 11'h000, 16'h5000 + 16'(k), 1'b0, 1'b0);
            chk(arr_we && arr_col == 8'(8'hFE + k) && arr_data == 16'h5000 + 16'(k),
                "R7 full page word", {15'd0, arr_we, arr_col, 8'd0},
                {15'd0, 1'b1, 8'(8'hFE + k), 8'd0});
        end
        put(4, 2'd0, 11'h400, 16'h0, 1'b0, 1'b0);
        chk(!arr_we, "R8 precharge-all stops full page", {31'd0, arr_we}, 32'd0);
        put(2, 2'd2, 11'h000, 16'h0, 1'b0, 1'b0);
        chk(proto_err && !arr_we, "R12 all banks closed", {31'd0, proto_err}, 32'd1);

        // R13: single word with auto-precharge closes the bank
        put(5, 2'd0, 11'h000, 16'h0, 1'b0, 1'b0);
        put(1, 2'd1, 11'h000, 16'h0, 1'b0, 1'b0);
        put(0, 2'd0, 11'h000, 16'h0, 1'b0, 1'b0);
        put(0, 2'd0, 11'h000, 16'h0, 1'b0, 1'b0);
        put(2, 2'd1, 11'h433, 16'h7777, 1'b0, 1'b0);
        chk(arr_we && arr_col == 8'h33 && arr_bank == 2'd1, "R13 single word",
            {22'd0, arr_we, arr_bank, arr_col}, {22'd0, 1'b1, 2'd1, 8'h33});
        put(0, 2'd0, 11'h000, 16'h0, 1'b0, 1'b0);
        chk(!arr_we, "R10 length one ends", {31'd0, arr_we}, 32'd0);
        put(2, 2'd1, 11'h000, 16'h0, 1'b0, 1'b0);
        chk(proto_err, "R13 bank closed by auto-precharge", {31'd0, proto_err}, 32'd1);

        // R1: deselected write pattern does nothing; R2: reserved code ignored
        put(1, 2'd1, 11'h000, 16'h0, 1'b0, 1'b0);
        put(0, 2'd0, 11'h000, 16'h0, 1'b0, 1'b0);
        put(0, 2'd0, 11'h000, 16'h0, 1'b0, 1'b0);
        put(2, 2'd1, 11'h020, 16'h1234, 1'b0, 1'b1);
        chk(!arr_we && !proto_err, "R1 deselected write ignored",
            {30'd0, arr_we, proto_err}, 32'd0);
        put(5, 2'd0, 11'h004, 16'h0, 1'b0, 1'b0);
        put(2, 2'd1, 11'h040, 16'h4040, 1'b0, 1'b0);
        chk(arr_we && arr_col == 8'h40 && arr_data == 16'h4040, "R2 write after reserved code",
            {7'd0, arr_we, arr_col, arr_data}, {7'd0, 1'b1, 8'h40, 16'h4040});
        put(0, 2'd0, 11'h000, 16'h4141, 1'b0, 1'b0);
        chk(!arr_we, "R2 reserved code kept length one", {31'd0, arr_we}, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule